// File: doc/BRIEF.md
# Bit-Serial Modular Multiplier

This block computes the product of two residues modulo an odd or even modulus, with every operand already below that modulus. It needs no hardware multiplier. An accumulator and a running multiplicand are updated once per clock. The multiplicand doubles on each step. When the lowest remaining bit of the multiplier is one, the multiplicand is added into the accumulator. Both values are brought back below the modulus after every step by at most one subtraction, so no wide product is ever formed. The block handles one multiplier bit per clock, so one product takes exactly as many clocks as the operand width. The default width is 254 bits.

A request is a single-cycle `start` with both operands and the modulus on the input ports. The block copies all three into registers and raises `busy`. It then iterates and drops `busy` in the same cycle that it raises `done` for one clock with `prod` valid. `prod` holds its value until the next completion. Requests that arrive while the block is working are dropped.

Top module: `sa_modmul`

## Requirements
- R1: For operands `opa`, `opb` below `modulus`, `prod` equals (opa·opb) mod modulus when `done` is high.
- R2: `done` is high in exactly the W-th clock after the clock edge that accepts `start`, where W is the operand width (254 by default).
- R3: `done` is high for one cycle only. `busy` is high from the cycle after acceptance until `done`, and low whenever `done` is high.
- R4: A `start` seen while `busy` is high has no effect on `prod` or on when `done` occurs. This includes a `start` on the last iteration edge, after which the block stays idle.
- R5: A zero operand in either position gives a product of zero.
- R6: Operands equal to modulus−1 give correct products, including (modulus−1)² = 1, with the modulus as large as 2^W−1.
- R7: After reset `busy`, `done` and `prod` are all zero.
- R8: `prod` changes only in a cycle where `done` is high, and holds between completions.
- R9: A `start` presented in the cycle where `done` is high is accepted, so back-to-back products are possible.
- R10: The modulus is captured at acceptance. Changing the `modulus` port while busy does not change the result.
- R11: The accumulator and the multiplicand stay below the captured modulus on every iteration, and `prod` is below the modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only when idle |
| opa | input | W | Multiplicand, below modulus |
| opb | input | W | Multiplier, scanned least significant bit first |
| modulus | input | W | Modulus, sampled with the request |
| busy | output | 1 | High while iterating |
| done | output | 1 | One-cycle completion strobe |
| prod | output | W | Modular product, held until next completion |

## Verification
Two events can land on the same edge, and each one is driven deliberately. The first is a new request arriving on the final iteration edge. The bench raises `start` with different operands and a different modulus one cycle before `done`. It then expects the first result to be unchanged, `done` to arrive on time, and `busy` to stay low afterwards. The second is a request issued in the very cycle `done` is high. That request must be accepted, and it must produce its own correct product exactly W cycles later. Random operands in the middle of a run, together with a mid-run modulus change, show that a request seen while busy is ignored.

// File: rtl/sa_modmul_pkg.sv
package sa_modmul_pkg;
  typedef enum logic {
    MM_IDLE = 1'b0,
    MM_RUN  = 1'b1
  } mm_state_e;
endpackage

// File: rtl/sa_modmul_addred.sv
// One modular addition: y = (x + z) mod m for x, z < m.
// The sum keeps one extra bit for the carry. The borrow out of (sum - m)
// picks the reduced or the raw sum, so no separate comparator is needed.
module sa_modmul_addred #(
  parameter int W = 254
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] z,
  input  logic [W-1:0] m,
  output logic [W-1:0] y
);
  logic [W:0] sum_w;
  logic [W:0] diff_w;

  always_comb begin
    sum_w  = {1'b0, x} + {1'b0, z};
    diff_w = sum_w - {1'b0, m};
    // diff_w[W] set means sum < m (a borrow), so keep the raw sum
    y = diff_w[W] ? sum_w[W-1:0] : diff_w[W-1:0];
  end
endmodule

// File: rtl/sa_modmul_step.sv
// Next-state arithmetic for one multiplier bit: a conditional accumulate
// and a doubling, each followed by its own reduction.
module sa_modmul_step #(
  parameter int W = 254
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mcand,
  input  logic         bit_sel,
  input  logic [W-1:0] m,
  output logic [W-1:0] acc_nx,
  output logic [W-1:0] mcand_nx
);
  logic [W-1:0] addend;

  assign addend = bit_sel ? mcand : '0;

  sa_modmul_addred #(.W(W)) u_acc_add (
    .x (acc),
    .z (addend),
    .m (m),
    .y (acc_nx)
  );

  sa_modmul_addred #(.W(W)) u_dbl_add (
    .x (mcand),
    .z (mcand),
    .m (m),
    .y (mcand_nx)
  );
endmodule

// File: rtl/sa_modmul.sv
module sa_modmul
  import sa_modmul_pkg::*;
#(
  parameter int W = 254
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] modulus,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mm_state_e    state_q;
  logic [W-1:0] acc_q, mcand_q, mult_q, p_q, prod_q;
  logic [CW-1:0] cnt_q;
  logic         done_q;
  logic [W-1:0] acc_nx, mcand_nx;

  sa_modmul_step #(.W(W)) u_step (
    .acc      (acc_q),
    .mcand    (mcand_q),
    .bit_sel  (mult_q[0]),
    .m        (p_q),
    .acc_nx   (acc_nx),
    .mcand_nx (mcand_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MM_IDLE;
      acc_q   <= '0;
      mcand_q <= '0;
      mult_q  <= '0;
      p_q     <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      prod_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        MM_IDLE: begin
          if (start) begin
            acc_q   <= '0;
            mcand_q <= opa;
            mult_q  <= opb;
            p_q     <= modulus;
            cnt_q   <= '0;
            state_q <= MM_RUN;
          end
        end
        MM_RUN: begin
          acc_q   <= acc_nx;
          mcand_q <= mcand_nx;
          mult_q  <= mult_q >> 1;
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            state_q <= MM_IDLE;
            done_q  <= 1'b1;
            prod_q  <= acc_nx;
          end
        end
        default: state_q <= MM_IDLE;
      endcase
    end
  end

  assign busy = (state_q == MM_RUN);
  assign done = done_q;
  assign prod = prod_q;
endmodule

// File: rtl/sa_modmul_chk.sv
module sa_modmul_chk #(
  parameter int W = 254
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] prod,
  input logic [W-1:0] acc,
  input logic [W-1:0] mcand,
  input logic [W-1:0] p_cap
);
  localparam int CW = $clog2(W + 1) + 1;

  // cycles spent busy since the last idle cycle, counted independently
  logic [CW-1:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst)       run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_cnt == CW'(W)));

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r3_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r4_busy_start_keeps_mod: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(p_cap));

  a_r7_reset_state: assert property (@(posedge clk)
    rst |=> (!busy && !done && (prod == '0)));

  a_r8_prod_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(prod) |-> done);

  a_r11_residues_below: assert property (@(posedge clk) disable iff (rst)
    busy |-> ((acc < p_cap) && (mcand < p_cap)));

  a_r11_prod_below: assert property (@(posedge clk) disable iff (rst)
    done |-> (prod < p_cap));
endmodule

bind sa_modmul sa_modmul_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .prod  (prod),
  .acc   (acc_q),
  .mcand (mcand_q),
  .p_cap (p_q)
);

// File: tb/sa_modmul_bench.sv
module sa_modmul_bench;
  localparam int W = 254;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYC = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] opa = '0, opb = '0, modulus = '0;
  logic         busy, done;
  logic [W-1:0] prod;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sa_modmul #(.W(W)) u_sa_modmul (
    .clk(clk), .rst(rst), .start(start), .opa(opa), .opb(opb),
    .modulus(modulus), .busy(busy), .done(done), .prod(prod)
  );

  function automatic logic [W-1:0] ref_modmul(logic [W-1:0] a, logic [W-1:0] b,
                                               logic [W-1:0] p);
    logic [2*W-1:0] t;
    t = ((2*W)'(a) * (2*W)'(b)) % (2*W)'(p);
    return t[W-1:0];
  endfunction

  function automatic logic [W-1:0] rnd_w();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r[W-1:0];
  endfunction

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue one request from a negedge. inject>0 raises a foreign start (with other
  // operands and modulus) at negedge number inject. chained=1 returns at the done
  // negedge so the caller can start again in that cycle.
  task automatic do_op(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] p,
                       int inject, bit chained);
    logic [W-1:0] expv;
    logic [W-1:0] held;
    int early;
    expv = ref_modmul(a, b, p);
    early = 0;
    start = 1'b1; opa = a; opb = b; modulus = p;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R3 busy after accept", W'(busy), W'(1));
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      if (k < W && done) early++;
      if (k == inject) begin
        start = 1'b1; opa = rnd_w() % p; opb = rnd_w(); modulus = p ^ W'(6);
      end else begin
        start = 1'b0; modulus = p;
      end
    end
    chk(early == 0, "R2 no early done", W'(early), W'(0));
    chk(done == 1'b1, "R2 done at W cycles", W'(done), W'(1));
    chk(busy == 1'b0, "R3 idle with done", W'(busy), W'(0));
    chk(prod == expv, inject > 0 ? "R1 R4 R10 product under busy start" : "R1 product",
        prod, expv);
    chk(prod < p, "R11 product below modulus", prod, p);
    if (!chained) begin
      held = prod;
      @(negedge clk);
      chk(done == 1'b0, "R3 done single cycle", W'(done), W'(0));
      chk(busy == 1'b0, "R4 no restart after ignored start", W'(busy), W'(0));
      @(negedge clk);
      chk(prod == held, "R8 product held", prod, held);
    end
  endtask

  initial begin
    logic [W-1:0] pbig, pmax, a, b;
    void'($urandom(32'd7319));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R7 reset busy", W'(busy), W'(0));
    chk(done == 1'b0, "R7 reset done", W'(done), W'(0));
    chk(prod == '0, "R7 reset prod", prod, '0);

    pbig = rnd_w();
    pbig[W-1] = 1'b1;
    pbig[0] = 1'b1;
    pmax = '1;

    // R5 zero operands
    do_op('0, pbig - 1, pbig, 0, 0);
    do_op(pbig - 1, '0, pbig, 0, 0);
    do_op('0, '0, W'(1), 0, 0);
    // R6 top residues
    do_op(pbig - 1, pbig - 1, pbig, 0, 0);
    do_op(pmax - 1, pmax - 1, pmax, 0, 0);
    do_op(pmax - 1, W'(2), pmax, 0, 0);
    do_op(W'(12), W'(11), W'(13), 0, 0);
    // R4 start on the last iteration edge, R10 modulus change mid-run
    do_op(rnd_w() % pbig, rnd_w() % pbig, pbig, W - 1, 0);
    do_op(rnd_w() % pbig, rnd_w() % pbig, pbig, 1, 0);
    // R9 back-to-back through the done cycle
    do_op(rnd_w() % pbig, rnd_w() % pbig, pbig, 0, 1);
    do_op(pbig - 1, pbig - 1, pbig, 0, 1);
    do_op(rnd_w() % pmax, rnd_w() % pmax, pmax, 0, 0);

    for (int i = 0; i < 24; i++) begin
      int inj;
      a = rnd_w() % pbig;
      b = rnd_w() % pbig;
      inj = ($urandom % 4 == 0) ? int'(1 + $urandom % (W - 1)) : 0;
      do_op(a, b, pbig, inj, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG_CYC, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule